// File: doc/BRIEF.md
# Time-Multiplexed Token Port

This block is the link between two stages of a cycle-level performance model in which one physical stage is shared by N virtual instances, served in a fixed round-robin order. Each virtual instance places exactly one token on the link per model cycle, and takes exactly one token from it per model cycle. A token is a payload plus a flag. The flag tells whether the token carries a real message or is only a no-message placeholder. The link is a FIFO with capacity `N_INST*LATENCY + 1`. It leaves reset already holding `N_INST*LATENCY` placeholder tokens. Because of that preload, the producer and the consumer can be working on different virtual instances, and on different model cycles, at the same time.

Both data sides are valid/ready streams. On the enqueue side, `enq_ready` is high when the FIFO is not full. When the FIFO is full, `enq_ready` follows `deq_ready`, so a push and a pop can both complete in the same clock. On the dequeue side, `deq_valid` is high whenever the FIFO holds at least one token, and the head token is held stable until it is taken. A token is transferred on a rising edge when valid and ready are both high. The port reports occupancy against the preload level as heavy (above it) or light (below it). Stages use that report to resynchronise without a central controller.

The port also contains a small firing gate that stands apart from the FIFO. A stage feeds it the availability and balance bits of all its ports. The gate says whether the stage may fire (every input holds a token and every output has room). It also says whether the stage should advance now (it may fire, and some input is heavy or some output is light).

Top module: `tmux_port`

## Requirements
- R1: After reset the occupancy is `N_INST*LATENCY`, `deq_valid` is 1, `empty`, `full`, `heavy` and `light` are 0, and every preloaded token has `deq_msg`=0 and `deq_data`=0.
- R2: The FIFO holds at most `N_INST*LATENCY+1` tokens. At that count `full`=1, and with `deq_ready`=0 the port drops `enq_ready` and refuses further tokens.
- R3: When the FIFO is full and `deq_ready`=1, `enq_ready` is 1. A push and a pop then complete in the same clock, and the occupancy stays at capacity.
- R4: Tokens leave in the order they entered: first the preloaded tokens, then the pushed tokens. The head token does not change while `deq_ready` is 0.
- R5: The message flag (`enq_msg`=1 for a real message, 0 for a no-message marker) and the payload reach `deq_msg` and `deq_data` unchanged.
- R6: `heavy`=1 exactly when occupancy > `N_INST*LATENCY`, and `light`=1 exactly when occupancy < `N_INST*LATENCY`.
- R7: At occupancy 0, `empty`=1 and `deq_valid`=0, no token is removed, and `enq_ready`=1.
- R8: `deq_inst` equals (pops since reset) mod `N_INST`, and `enq_inst` equals (`N_INST*LATENCY` + pushes since reset) mod `N_INST`. These are the virtual instances that own the head token and the next pushed token.
- R9: `gate_fire`=1 exactly when every bit of `gate_in_avail` and every bit of `gate_out_space` is 1.
- R10: `gate_advance`=1 exactly when `gate_fire`=1 and at least one bit of `gate_in_heavy` or `gate_out_light` is 1.
- R11: `occupancy` reports the number of tokens held: the count at reset, plus pushes, minus pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Producer offers a token |
| enq_ready | output | 1 | Port accepts the offered token |
| enq_msg | input | 1 | 1 = real message, 0 = no-message marker |
| enq_data | input | PAY_W | Token payload |
| enq_inst | output | IW | Virtual instance that owns the next pushed token |
| deq_valid | output | 1 | Head token present |
| deq_ready | input | 1 | Consumer takes the head token |
| deq_msg | output | 1 | Message flag of the head token |
| deq_data | output | PAY_W | Payload of the head token |
| deq_inst | output | IW | Virtual instance that owns the head token |
| occupancy | output | CW | Tokens held |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy is at capacity |
| heavy | output | 1 | Occupancy above the preload level |
| light | output | 1 | Occupancy below the preload level |
| gate_in_avail | input | GATE_IN | Per input port of the stage: holds a token |
| gate_in_heavy | input | GATE_IN | Per input port of the stage: is heavy |
| gate_out_space | input | GATE_OUT | Per output port of the stage: has room |
| gate_out_light | input | GATE_OUT | Per output port of the stage: is light |
| gate_fire | output | 1 | Stage may fire |
| gate_advance | output | 1 | Stage should fire now to rebalance |

## Verification
The bench goes after the edges of the occupancy range. It drains the preload to zero, where a design with an off-by-one count would hand out a stale token or refuse a push. It fills to one token above the preload, where a design sized to `N*L` would raise `full` too early, or a design with no capacity check would overwrite the head. It pushes and pops together on a full FIFO, where a design that gates `enq_ready` on `full` alone would stall the producer. A long mixed stream checks that placeholder and message flags come out in push order and carry the right instance tags, which would break if the preload were placed at the wrong pointer or the tag counters wrapped wrongly. The heavy/light boundary at exactly the preload level is checked as well, along with all 256 input combinations of the firing gate.

// File: rtl/tmux_port_pkg.sv
package tmux_port_pkg;

  // Occupancy relative to the preload level.
  typedef enum logic [1:0] {
    BAL_LIGHT = 2'd0,
    BAL_EVEN  = 2'd1,
    BAL_HEAVY = 2'd2
  } bal_e;

  // Index width that stays at least one bit wide for tiny counts.
  function automatic int unsigned idx_width(input int unsigned n);
    if (n < 2) return 1;
    return $clog2(n);
  endfunction

endpackage

// File: rtl/tmux_token_ring.sv
module tmux_token_ring
  import tmux_port_pkg::*;
#(
  parameter int unsigned TOK_W   = 9,
  parameter int unsigned DEPTH   = 9,
  parameter int unsigned PRELOAD = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [TOK_W-1:0] wr_tok,
  output logic [TOK_W-1:0] rd_tok
);
  localparam int unsigned PW = idx_width(DEPTH);
  localparam logic [PW-1:0] LAST    = PW'(DEPTH - 1);
  localparam logic [PW-1:0] WR_INIT = PW'(PRELOAD % DEPTH);

  logic [PW-1:0]    wr_ptr;
  logic [PW-1:0]    rd_ptr;
  logic [TOK_W-1:0] slot [DEPTH];

  // Write pointer starts past the preloaded placeholders.
  always_ff @(posedge clk) begin
    if (!rst_n)    wr_ptr <= WR_INIT;
    else if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   rd_ptr <= '0;
    else if (pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
  end

  // Every slot resets to a no-message token with a zero payload.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) slot[i] <= '0;
    end else if (push) begin
      slot[wr_ptr] <= wr_tok;
    end
  end

  assign rd_tok = slot[rd_ptr];

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr <= LAST) && (rd_ptr <= LAST)); // R2

endmodule

// File: rtl/tmux_occupancy.sv
module tmux_occupancy
  import tmux_port_pkg::*;
#(
  parameter int unsigned DEPTH   = 9,
  parameter int unsigned PRELOAD = 8,
  parameter int unsigned CW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          heavy,
  output logic          light
);
  localparam logic [CW-1:0] CNT_INIT = CW'(PRELOAD);
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);

  bal_e level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= CNT_INIT;
    end else begin
      unique case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    if (count > CNT_INIT)      level = BAL_HEAVY;
    else if (count < CNT_INIT) level = BAL_LIGHT;
    else                       level = BAL_EVEN;
  end

  assign empty = (count == '0);
  assign full  = (count == CNT_MAX);
  assign heavy = (level == BAL_HEAVY);
  assign light = (level == BAL_LIGHT);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> !full); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R7
  AST_HEAVY_ON_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !light) |=> heavy); // R6

endmodule

// File: rtl/tmux_inst_track.sv
module tmux_inst_track
  import tmux_port_pkg::*;
#(
  parameter int unsigned N_INST  = 4,
  parameter int unsigned PRELOAD = 8,
  parameter int unsigned IW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [IW-1:0] enq_inst,
  output logic [IW-1:0] deq_inst
);
  localparam logic [IW-1:0] LAST_INST = IW'(N_INST - 1);
  localparam logic [IW-1:0] ENQ_INIT  = IW'(PRELOAD % N_INST);

  // Round-robin owner of the next pushed token.
  always_ff @(posedge clk) begin
    if (!rst_n)    enq_inst <= ENQ_INIT;
    else if (push) enq_inst <= (enq_inst == LAST_INST) ? '0 : enq_inst + 1'b1;
  end

  // Round-robin owner of the head token.
  always_ff @(posedge clk) begin
    if (!rst_n)   deq_inst <= '0;
    else if (pop) deq_inst <= (deq_inst == LAST_INST) ? '0 : deq_inst + 1'b1;
  end

  AST_INST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_inst <= LAST_INST) && (deq_inst <= LAST_INST)); // R8

endmodule

// File: rtl/tmux_fire_gate.sv
module tmux_fire_gate #(
  parameter int unsigned GATE_IN  = 2,
  parameter int unsigned GATE_OUT = 2
) (
  input  logic [GATE_IN-1:0]  in_avail,
  input  logic [GATE_IN-1:0]  in_heavy,
  input  logic [GATE_OUT-1:0] out_space,
  input  logic [GATE_OUT-1:0] out_light,
  output logic                fire,
  output logic                advance
);
  logic all_in;
  logic all_out;
  logic rebalance;

  assign all_in    = &in_avail;
  assign all_out   = &out_space;
  assign rebalance = (|in_heavy) | (|out_light);
  assign fire      = all_in & all_out;
  assign advance   = fire & rebalance;

endmodule

// File: rtl/tmux_port.sv
module tmux_port
  import tmux_port_pkg::*;
#(
  parameter int unsigned N_INST   = 4,
  parameter int unsigned LATENCY  = 2,
  parameter int unsigned PAY_W    = 8,
  parameter int unsigned GATE_IN  = 2,
  parameter int unsigned GATE_OUT = 2,
  localparam int unsigned PRELOAD = N_INST * LATENCY,
  localparam int unsigned DEPTH   = PRELOAD + 1,
  localparam int unsigned CW      = idx_width(DEPTH + 1),
  localparam int unsigned IW      = idx_width(N_INST)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enq_valid,
  output logic                enq_ready,
  input  logic                enq_msg,
  input  logic [PAY_W-1:0]    enq_data,
  output logic [IW-1:0]       enq_inst,
  output logic                deq_valid,
  input  logic                deq_ready,
  output logic                deq_msg,
  output logic [PAY_W-1:0]    deq_data,
  output logic [IW-1:0]       deq_inst,
  output logic [CW-1:0]       occupancy,
  output logic                empty,
  output logic                full,
  output logic                heavy,
  output logic                light,
  input  logic [GATE_IN-1:0]  gate_in_avail,
  input  logic [GATE_IN-1:0]  gate_in_heavy,
  input  logic [GATE_OUT-1:0] gate_out_space,
  input  logic [GATE_OUT-1:0] gate_out_light,
  output logic                gate_fire,
  output logic                gate_advance
);
  localparam int unsigned TOK_W = PAY_W + 1;

  logic             push;
  logic             pop;
  logic [TOK_W-1:0] wr_tok;
  logic [TOK_W-1:0] rd_tok;

  assign deq_valid = !empty;
  assign enq_ready = !full || deq_ready;
  assign push      = enq_valid && enq_ready;
  assign pop       = deq_valid && deq_ready;
  assign wr_tok    = {enq_msg, enq_data};
  assign deq_msg   = rd_tok[TOK_W-1];
  assign deq_data  = rd_tok[PAY_W-1:0];

  tmux_token_ring #(
    .TOK_W   (TOK_W),
    .DEPTH   (DEPTH),
    .PRELOAD (PRELOAD)
  ) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .pop    (pop),
    .wr_tok (wr_tok),
    .rd_tok (rd_tok)
  );

  tmux_occupancy #(
    .DEPTH   (DEPTH),
    .PRELOAD (PRELOAD),
    .CW      (CW)
  ) u_occ (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .count (occupancy),
    .empty (empty),
    .full  (full),
    .heavy (heavy),
    .light (light)
  );

  tmux_inst_track #(
    .N_INST  (N_INST),
    .PRELOAD (PRELOAD),
    .IW      (IW)
  ) u_inst (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .enq_inst (enq_inst),
    .deq_inst (deq_inst)
  );

  tmux_fire_gate #(
    .GATE_IN  (GATE_IN),
    .GATE_OUT (GATE_OUT)
  ) u_gate (
    .in_avail  (gate_in_avail),
    .in_heavy  (gate_in_heavy),
    .out_space (gate_out_space),
    .out_light (gate_out_light),
    .fire      (gate_fire),
    .advance   (gate_advance)
  );

  // Instance tags and occupancy must agree modulo the instance count.
  logic inst_consistent;
  assign inst_consistent =
    (((int'(enq_inst) + int'(N_INST) - int'(deq_inst)) % int'(N_INST))
      == (int'(occupancy) % int'(N_INST)));

  AST_INST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    inst_consistent); // R8
  AST_FULL_SWAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop) |=> full); // R3
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && !deq_ready) |=> (deq_valid && $stable(deq_data) && $stable(deq_msg))); // R4
  AST_ADVANCE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    gate_advance |-> gate_fire); // R10

endmodule

// File: tb/tmux_port_test.sv
module tmux_port_test;
  localparam int N    = 4;
  localparam int L    = 2;
  localparam int W    = 8;
  localparam int GI   = 2;
  localparam int GO   = 2;
  localparam int PRE  = N * L;
  localparam int DEP  = PRE + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enq_valid = 1'b0;
  logic         enq_ready;
  logic         enq_msg = 1'b0;
  logic [W-1:0] enq_data = '0;
  logic [1:0]   enq_inst;
  logic         deq_valid;
  logic         deq_ready = 1'b0;
  logic         deq_msg;
  logic [W-1:0] deq_data;
  logic [1:0]   deq_inst;
  logic [3:0]   occupancy;
  logic         empty, full, heavy, light;
  logic [GI-1:0] g_in_avail = '0, g_in_heavy = '0;
  logic [GO-1:0] g_out_space = '0, g_out_light = '0;
  logic         gate_fire, gate_advance;

  always #2 clk = ~clk;

  tmux_port #(.N_INST(N), .LATENCY(L), .PAY_W(W), .GATE_IN(GI), .GATE_OUT(GO)) uut (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_msg(enq_msg),
    .enq_data(enq_data), .enq_inst(enq_inst),
    .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_msg(deq_msg),
    .deq_data(deq_data), .deq_inst(deq_inst),
    .occupancy(occupancy), .empty(empty), .full(full), .heavy(heavy), .light(light),
    .gate_in_avail(g_in_avail), .gate_in_heavy(g_in_heavy),
    .gate_out_space(g_out_space), .gate_out_light(g_out_light),
    .gate_fire(gate_fire), .gate_advance(gate_advance)
  );

  int checks = 0;
  int fails  = 0;

  // Reference queue, built from the requirements.
  logic [W:0] mq [64];
  int mh, mt, mcnt, n_enq, n_deq;

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) mq[i] = '0;
    mh = 0; mt = PRE; mcnt = PRE; n_enq = 0; n_deq = 0;
  endtask

  task automatic step(input bit ev, input bit em, input logic [W-1:0] ed, input bit dr);
    bit acc_e, acc_d;
    @(negedge clk);
    enq_valid = ev; enq_msg = em; enq_data = ed; deq_ready = dr;
    #1;
    chk_eq("R11", "occupancy", int'(occupancy), mcnt);
    chk_eq("R6", "heavy", int'(heavy), int'(mcnt > PRE));
    chk_eq("R6", "light", int'(light), int'(mcnt < PRE));
    chk_eq("R7", "deq_valid", int'(deq_valid), int'(mcnt > 0));
    chk_eq("R7", "empty", int'(empty), int'(mcnt == 0));
    chk_eq("R2", "full", int'(full), int'(mcnt == DEP));
    chk_eq("R3", "enq_ready", int'(enq_ready), int'((mcnt < DEP) || dr));
    chk_eq("R8", "enq_inst", int'(enq_inst), (PRE + n_enq) % N);
    if (mcnt > 0) begin
      chk_eq("R5", "deq_msg", int'(deq_msg), int'(mq[mh % 64][W]));
      chk_eq("R4", "deq_data", int'(deq_data), int'(mq[mh % 64][W-1:0]));
      chk_eq("R8", "deq_inst", int'(deq_inst), n_deq % N);
    end
    acc_e = ev && ((mcnt < DEP) || dr);
    acc_d = dr && (mcnt > 0);
    @(posedge clk);
    if (acc_d) begin mh++; mcnt--; n_deq++; end
    if (acc_e) begin mq[mt % 64] = {em, ed}; mt++; mcnt++; n_enq++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1: state straight after reset
    chk_eq("R1", "occupancy", int'(occupancy), PRE);
    chk_eq("R1", "deq_valid", int'(deq_valid), 1);
    chk_eq("R1", "flags", int'({empty, full, heavy, light}), 0);
    chk_eq("R1", "deq_msg", int'(deq_msg), 0);
    chk_eq("R1", "deq_data", int'(deq_data), 0);

    // R1/R4/R8: drain the placeholders, then poke the empty FIFO (R7)
    for (int i = 0; i < PRE; i++) step(1'b0, 1'b0, '0, 1'b1);
    step(1'b0, 1'b0, '0, 1'b1);
    step(1'b0, 1'b0, '0, 1'b0);

    // R2/R5: fill to capacity with mixed message flags, then a refused push
    for (int i = 0; i < DEP; i++) step(1'b1, (i % 3) != 0, W'(i * 37 + 5), 1'b0);
    step(1'b1, 1'b1, 8'hAA, 1'b0);
    step(1'b0, 1'b0, '0, 1'b0);

    // R3: push and pop together while full
    for (int i = 0; i < 3; i++) step(1'b1, i[0], W'(8'h5C + i), 1'b1);

    // R4-R8/R11: mixed streams at several push/pop rates
    lfsr = 16'hACE1;
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 400; c++) begin
        bit ev, dr;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (p)
          0: begin ev = lfsr[0];               dr = lfsr[1];               end
          1: begin ev = lfsr[0] | lfsr[2];     dr = lfsr[1] & lfsr[3];     end
          2: begin ev = lfsr[0] & lfsr[2];     dr = lfsr[1] | lfsr[3];     end
          default: begin ev = 1'b1;            dr = lfsr[4] | lfsr[5];     end
        endcase
        step(ev, lfsr[6], lfsr[15:8], dr);
      end
    end

    // R7: drain everything and confirm empty
    for (int i = 0; i < DEP + 2; i++) step(1'b0, 1'b0, '0, 1'b1);
    step(1'b0, 1'b0, '0, 1'b0);

    // R9/R10: every combination of the firing gate inputs
    for (int v = 0; v < 256; v++) begin
      bit ef, ea;
      @(negedge clk);
      g_in_avail  = v[1:0];
      g_in_heavy  = v[3:2];
      g_out_space = v[5:4];
      g_out_light = v[7:6];
      #1;
      ef = (v[1:0] == 2'b11) && (v[5:4] == 2'b11);
      ea = ef && ((v[3:2] != 0) || (v[7:6] != 0));
      chk_eq("R9", "gate_fire", int'(gate_fire), int'(ef));
      chk_eq("R10", "gate_advance", int'(gate_advance), int'(ea));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule